// File: doc/BRIEF.md
# Shared-Classifier PUF Response Sequencer

This block turns a bank of N cross-coupled latch cells into a 2N-bit identification response. It uses one ternary classifier for every cell in the bank. After a start request it enables the bank and drives a slow excitation clock, which is the system clock divided by an even factor. It then visits the cells one at a time, from index 0 upward. For each cell, a multiplexer and a capture flop pass the cell's output to the classifier once per excitation period, for a window of a fixed number of samples.

The classifier's code has three values:
- all samples low gives 00;
- all samples high gives 11;
- any change within the window gives 10. This code is sticky.

Each code lands in its own bit pair of the response. When the last cell has been classified, the block drops busy, disables the bank and pulses done. The response then holds until the next accepted start. Sharing one classifier costs time: N windows run one after another. In return the design has a single sample counter and comparator instead of N of them.

Top module: `puf_resp_seq`

## Requirements
- R1: A start pulse seen while busy is low is accepted. On the next cycle busy and cell_en are high and response reads all zeros.
- R2: cell_en equals busy. While busy, cell_exc is a square wave of period EXC_DIV cycles, high for the first EXC_DIV/2 cycles. It is high in the first cycle after the start is accepted. While idle, both cell_en and cell_exc are low.
- R3: sample_stb pulses once per excitation period, in the last high cycle of cell_exc. A full response uses exactly N_CELLS*WIN_LEN strobes and N_CELLS*WIN_LEN excitation periods.
- R4: A cell is classified from WIN_LEN consecutive samples. All zeros give code 00, all ones give 11, and any change anywhere in the window gives 10, including a change only at the first or only at the last sample. The code 01 never occurs.
- R5: The code of cell i sits at response bits [2i+1:2i], so higher cells occupy more significant pairs.
- R6: Cells are classified in ascending order, WIN_LEN samples each. done is first seen high EXC_DIV/2 + 2 + (N_CELLS*WIN_LEN-1)*EXC_DIV clock edges after the edge that accepted start.
- R7: done is high for exactly one cycle. In that same cycle busy has just fallen and cell_en is low.
- R8: After done, response holds its value until the next accepted start.
- R9: A start pulse while busy has no effect: the response value and the completion time are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to generate a response |
| cell_out | input | N_CELLS | Outputs of the latch cell bank |
| cell_en | output | 1 | Enable for the cell bank, high only during generation |
| cell_exc | output | 1 | Slow excitation clock for the cell bank |
| sample_stb | output | 1 | One pulse per excitation period, at the sampling point |
| response | output | 2*N_CELLS | Packed ternary codes, cell i at bits [2i+1:2i] |
| busy | output | 1 | Generation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench models cells that change only at the first sample of their window, or only at the last. A classifier that skips either end of the window, or loses its sticky flag, reports such a cell as fixed. A window that ends one sample early or late shifts every later cell, which garbles the packed word and moves the completion edge; both are checked against the stated formula. A stray start in the middle of generation tests R9: a design that restarts on it produces a late completion and a response that no longer matches the model. Patterns with alternating fixed cells would expose a pair placed in the wrong position or in reversed order.

// File: rtl/puf_seq_pkg.sv
package puf_seq_pkg;

   typedef enum logic [1:0] {
      TERN_ZERO = 2'b00,
      TERN_RAND = 2'b10,
      TERN_ONE  = 2'b11
   } tern_code_e;

   function automatic tern_code_e tern_encode(input logic changed, input logic level);
      if (changed)
         return TERN_RAND;
      return level ? TERN_ONE : TERN_ZERO;
   endfunction

endpackage

// File: rtl/puf_seq_exciter.sv
module puf_seq_exciter #(
   parameter int EXC_DIV = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic exc,
   output logic stb
);
   localparam int HALF = EXC_DIV / 2;
   localparam int CW   = $clog2(EXC_DIV);

   logic [CW-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= '0;
      else if (!run || phase_q == CW'(EXC_DIV - 1))
         phase_q <= '0;
      else
         phase_q <= phase_q + 1'b1;
   end

   assign exc = run && (phase_q < CW'(HALF));
   assign stb = run && (phase_q == CW'(HALF - 1));

endmodule

// File: rtl/puf_seq_pick.sv
module puf_seq_pick #(
   parameter int N_CELLS = 8,
   parameter int IW      = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_CELLS-1:0] cells,
   input  logic [IW-1:0]      sel,
   input  logic               stb_in,
   output logic               bit_q,
   output logic               vld_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= 1'b0;
         vld_q <= 1'b0;
      end else begin
         bit_q <= cells[sel];
         vld_q <= stb_in;
      end
   end

endmodule

// File: rtl/puf_seq_classifier.sv
module puf_seq_classifier
   import puf_seq_pkg::*;
#(
   parameter int WIN_LEN = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       vld,
   input  logic       smp,
   output logic       win_done,
   output tern_code_e code
);
   localparam int CW = $clog2(WIN_LEN);

   logic [CW-1:0] n_q;
   logic          level_q;
   logic          moved_q;
   logic          fin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q     <= '0;
         level_q <= 1'b0;
         moved_q <= 1'b0;
         fin_q   <= 1'b0;
      end else if (clr || fin_q) begin
         n_q     <= '0;
         moved_q <= 1'b0;
         fin_q   <= 1'b0;
      end else if (vld) begin
         if (n_q == '0)
            level_q <= smp;
         else if (smp != level_q)
            moved_q <= 1'b1;
         n_q   <= (n_q == CW'(WIN_LEN - 1)) ? '0 : n_q + 1'b1;
         fin_q <= (n_q == CW'(WIN_LEN - 1));
      end
   end

   assign win_done = fin_q;
   assign code     = tern_encode(moved_q, level_q);

endmodule

// File: rtl/puf_resp_seq.sv
module puf_resp_seq
   import puf_seq_pkg::*;
#(
   parameter int N_CELLS = 8,
   parameter int EXC_DIV = 20,
   parameter int WIN_LEN = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [N_CELLS-1:0]   cell_out,
   output logic                 cell_en,
   output logic                 cell_exc,
   output logic                 sample_stb,
   output logic [2*N_CELLS-1:0] response,
   output logic                 busy,
   output logic                 done
);
   localparam int IW = (N_CELLS > 1) ? $clog2(N_CELLS) : 1;

   if (N_CELLS < 1) begin : g_bad_cells
      $error("N_CELLS must be at least 1");
   end
   if (EXC_DIV < 4 || (EXC_DIV % 2) != 0) begin : g_bad_div
      $error("EXC_DIV must be even and at least 4");
   end
   if (WIN_LEN < 2) begin : g_bad_win
      $error("WIN_LEN must be at least 2");
   end

   logic          busy_q, done_q;
   logic [IW-1:0] idx_q;
   logic          take;
   logic          stb_w, exc_w;
   logic          smp_bit, smp_vld;
   logic          cls_done;
   tern_code_e    cls_code;

   assign take = start && !busy_q;

   puf_seq_exciter #(.EXC_DIV(EXC_DIV)) u_exc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy_q),
      .exc   (exc_w),
      .stb   (stb_w)
   );

   puf_seq_pick #(.N_CELLS(N_CELLS), .IW(IW)) u_pick (
      .clk    (clk),
      .rst_n  (rst_n),
      .cells  (cell_out),
      .sel    (idx_q),
      .stb_in (stb_w),
      .bit_q  (smp_bit),
      .vld_q  (smp_vld)
   );

   puf_seq_classifier #(.WIN_LEN(WIN_LEN)) u_cls (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (take),
      .vld      (smp_vld),
      .smp      (smp_bit),
      .win_done (cls_done),
      .code     (cls_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         idx_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (take) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
         end else if (busy_q && cls_done) begin
            if (idx_q == IW'(N_CELLS - 1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   for (genvar gi = 0; gi < N_CELLS; gi++) begin : g_pair
      logic [1:0] pair_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pair_q <= 2'b00;
         else if (take)
            pair_q <= 2'b00;
         else if (busy_q && cls_done && idx_q == IW'(gi))
            pair_q <= cls_code;
      end
      assign response[2*gi +: 2] = pair_q;
   end

   assign busy       = busy_q;
   assign done       = done_q;
   assign cell_en    = busy_q;
   assign cell_exc   = exc_w;
   assign sample_stb = stb_w;

endmodule

// File: rtl/puf_resp_seq_chk.sv
module puf_resp_seq_chk #(
   parameter int N_CELLS = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start,
   input logic                 cell_en,
   input logic                 cell_exc,
   input logic                 sample_stb,
   input logic [2*N_CELLS-1:0] response,
   input logic                 busy,
   input logic                 done
);
   assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && cell_en && response == '0));

   assert_exc_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cell_exc |-> cell_en);

   assert_stb_in_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> (cell_exc && cell_en));

   assert_stb_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !sample_stb);

   for (genvar gi = 0; gi < N_CELLS; gi++) begin : g_code
      assert_no_code01_R4: assert property (@(posedge clk) disable iff (!rst_n)
         response[2*gi +: 2] != 2'b01);
   end

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_busy_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($fell(busy) && !cell_en));

   assert_resp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(response));

endmodule

bind puf_resp_seq puf_resp_seq_chk #(.N_CELLS(N_CELLS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .cell_en    (cell_en),
   .cell_exc   (cell_exc),
   .sample_stb (sample_stb),
   .response   (response),
   .busy       (busy),
   .done       (done)
);

// File: tb/puf_resp_seq_tb.sv
module puf_resp_seq_tb;
   localparam int N    = 8;
   localparam int DIV  = 20;
   localparam int WIN  = 16;
   localparam int HALF = DIV / 2;
   localparam int LAT  = HALF + 3 + (N * WIN - 1) * DIV;
   localparam int NV   = 5;

   // cell kinds, one hex digit per cell (cell i at digit i):
   // 0 stuck low, 1 stuck high, 2 toggles every excitation,
   // 3 high only at the last sample of its window, 4 high only at the first
   localparam logic [31:0] KINDS [NV] = '{
      32'h0000_0000, 32'h1111_1111, 32'h1010_1010, 32'h0120_1432, 32'h2222_2222};
   localparam logic [15:0] EXPECT [NV] = '{
      16'h0000, 16'hFFFF, 16'hCCCC, 16'h38EA, 16'hAAAA};

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [N-1:0]   cell_out = '0;
   logic           cell_en, cell_exc, sample_stb, busy, done;
   logic [2*N-1:0] response;

   int checks = 0;
   int fails  = 0;
   logic [31:0] cur_kinds = '0;
   int rises = 0, rise_base = 0, stb_cnt = 0;
   logic prev_exc = 1'b0;

   always #10 clk = ~clk;

   puf_resp_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cell_out(cell_out),
      .cell_en(cell_en), .cell_exc(cell_exc), .sample_stb(sample_stb),
      .response(response), .busy(busy), .done(done));

   // cell bank model: new value at each rise of the excitation clock
   always @(negedge clk) begin
      if (sample_stb) stb_cnt = stb_cnt + 1;
      if (cell_exc && !prev_exc) begin
         rises = rises + 1;
         for (int i = 0; i < N; i++) begin
            int s;
            s = rises - rise_base - 1;
            case (cur_kinds[4*i +: 4])
               4'd1:    cell_out[i] = 1'b1;
               4'd2:    cell_out[i] = s[0];
               4'd3:    cell_out[i] = (s == i * WIN + WIN - 1);
               4'd4:    cell_out[i] = (s == i * WIN);
               default: cell_out[i] = 1'b0;
            endcase
         end
      end
      prev_exc = cell_exc;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_one(input int v, input bit stray);
      int lat;
      int sb;
      @(negedge clk);
      cur_kinds = KINDS[v];
      rise_base = rises;
      sb = stb_cnt;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy && cell_en && response == '0, "R1", "accept start",
            {busy, cell_en, response}, {2'b11, 16'h0});
      lat = 1;
      while (!done && lat < LAT + 200) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (stray && lat == 500) start = 1'b1;
         if (stray && lat == 501) start = 1'b0;
      end
      check(done == 1'b1, "R7", "done seen", done, 1);
      check(lat == LAT, stray ? "R9" : "R6", "completion edge", lat, LAT);
      check(response == EXPECT[v], (v == 2) ? "R5" : "R4", "response",
            response, EXPECT[v]);
      check(stb_cnt - sb == N * WIN, "R3", "strobe count", stb_cnt - sb, N * WIN);
      check(rises - rise_base == N * WIN, "R2", "excitation count",
            rises - rise_base, N * WIN);
      @(negedge clk);
      check(!done && !busy && !cell_en && !cell_exc, "R7", "after done",
            {done, busy, cell_en, cell_exc}, 0);
      repeat (5) @(negedge clk);
      check(response == EXPECT[v], "R8", "response held", response, EXPECT[v]);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !cell_en && !cell_exc && response == '0, "R1",
            "reset state", {busy, done, cell_en, cell_exc, response}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!cell_en && !cell_exc && !sample_stb, "R2", "idle outputs",
            {cell_en, cell_exc, sample_stb}, 0);
      for (int v = 0; v < NV; v++) run_one(v, 1'b0);
      // directed: stray start during generation on the mixed pattern
      run_one(3, 1'b1);
      // directed: a new start after a finished response clears it
      run_one(1, 1'b0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule